// File: doc/BRIEF.md
# Auxiliary Register Address Unit

This unit holds eight 16-bit address registers and a 3-bit pointer that picks the active one. On an indirect data-memory access, the unit drives the active register's current value as the memory address. At the same clock edge it can update that register in place. The update can add or subtract one, or add or subtract the index register (register 0). It can also do the index add or subtract with the carry running in reverse bit order, which walks a buffer in the order an FFT needs. The same access can load a new pointer value, so the next access uses a different register. All of this address work runs beside the main datapath and needs none of its cycles.

Registers, the pointer and a 9-bit page register are loaded from a load value. A select input takes that value from either the data bus or an immediate field. Any register can be read back for storing, and the pointer and page are visible on outputs. In direct mode, the address is built from the page register and a 7-bit offset taken from the instruction.

Top module: `aux_addr_unit`

## Requirements
- R1: After reset, all eight registers, the pointer and the page register read zero.
- R2: When `ar_we` is high, register `wr_idx` takes the load value at the clock edge. The load value is `imm_data` when `src_imm` is 1 and `bus_data` when it is 0. `rd_data` shows register `rd_idx` combinationally.
- R3: `ptr_we` loads the pointer from bits 2:0 of the load value. `page_we` loads the page register from bits 8:0 of the load value.
- R4: During an indirect access (`acc_en`=1, `dir_sel`=0), `mem_addr` equals the active register's value before any post-modify.
- R5: Post-modify code 1 adds 1 to the active register and code 2 subtracts 1, both modulo 2^16.
- R6: Code 3 adds register 0 to the active register and code 4 subtracts register 0, both modulo 2^16.
- R7: Code 5 adds register 0 and code 6 subtracts register 0, with the carry or borrow running from bit 15 toward bit 0. Starting from 0 with register 0 = 8, code 5 gives 0,8,4,C,2,A,6,E,1,9 and code 6 gives 0,F,7.
- R8: Codes 0 and 7, and any cycle with `acc_en` low, leave the registers unchanged.
- R9: An indirect access with `ptr_ld` high sets the pointer to `ptr_new` after the access. The register selected by the old pointer is still the one post-modified. Without a load, the pointer holds.
- R10: With `dir_sel` high, `mem_addr` is {page, `dir_off`}, and no register is post-modified.
- R11: A register write beats a post-modify of the same register in the same cycle, and `ptr_we` beats `ptr_ld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 16 | Load value from the data bus |
| imm_data | input | 16 | Load value from the immediate field |
| src_imm | input | 1 | 1 selects the immediate, 0 the bus |
| ar_we | input | 1 | Register write enable |
| wr_idx | input | 3 | Register to write |
| ptr_we | input | 1 | Pointer write enable |
| page_we | input | 1 | Page register write enable |
| acc_en | input | 1 | Indirect access strobe |
| mode | input | 3 | Post-modify code |
| ptr_ld | input | 1 | Replace the pointer after the access |
| ptr_new | input | 3 | New pointer value |
| dir_sel | input | 1 | Direct addressing select |
| dir_off | input | 7 | Direct-mode offset |
| rd_idx | input | 3 | Register to read back |
| mem_addr | output | 16 | Data-memory address |
| rd_data | output | 16 | Read-back value |
| ptr_out | output | 3 | Current pointer |
| page_out | output | 9 | Current page |

## Verification
The hardest case to reach is a single cycle in which an access post-modifies one register, loads a new pointer, and collides with an explicit write. The stimulus sets up the registers with immediate and bus loads, then drives access strobes and write enables together in one cycle. Afterwards it reads each affected register back through `rd_idx`. The reversed-carry walks run ten steps from a known base with register 0 set to 8, so every carry chain length from one bit to four bits appears in the output.

// File: rtl/aux_addr_unit.sv
module aux_addr_unit #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int PGW  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DW-1:0]           bus_data,
  input  logic [DW-1:0]           imm_data,
  input  logic                    src_imm,
  input  logic                    ar_we,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic                    ptr_we,
  input  logic                    page_we,
  input  logic                    acc_en,
  input  logic [2:0]              mode,
  input  logic                    ptr_ld,
  input  logic [$clog2(NREG)-1:0] ptr_new,
  input  logic                    dir_sel,
  input  logic [DW-PGW-1:0]       dir_off,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [DW-1:0]           mem_addr,
  output logic [DW-1:0]           rd_data,
  output logic [$clog2(NREG)-1:0] ptr_out,
  output logic [PGW-1:0]          page_out
);
  localparam int PTRW = $clog2(NREG);
  localparam logic [2:0] M_INC = 3'd1, M_DEC = 3'd2, M_ADD = 3'd3,
                         M_SUB = 3'd4, M_RADD = 3'd5, M_RSUB = 3'd6;

  logic [DW-1:0]   regs [NREG];
  logic [PTRW-1:0] ptr;
  logic [PGW-1:0]  page;
  logic [DW-1:0]   nxt;

  wire [DW-1:0] ld_val = src_imm ? imm_data : bus_data;
  wire [DW-1:0] cur    = regs[ptr];
  wire [DW-1:0] idx    = regs[0];
  wire          ind    = acc_en & ~dir_sel;
  wire          do_mod = ind & (mode != 3'd0) & (mode != 3'd7);

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] v);
    for (int b = 0; b < DW; b++) flip[b] = v[DW-1-b];
  endfunction

  always_comb begin
    case (mode)
      M_INC:   nxt = cur + DW'(1);
      M_DEC:   nxt = cur - DW'(1);
      M_ADD:   nxt = cur + idx;
      M_SUB:   nxt = cur - idx;
      M_RADD:  nxt = flip(flip(cur) + flip(idx));
      M_RSUB:  nxt = flip(flip(cur) - flip(idx));
      default: nxt = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      ptr  <= '0;
      page <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (ar_we && wr_idx == PTRW'(i)) regs[i] <= ld_val;
        else if (do_mod && ptr == PTRW'(i)) regs[i] <= nxt;
      end
      if (ptr_we)           ptr <= ld_val[PTRW-1:0];
      else if (ind && ptr_ld) ptr <= ptr_new;
      if (page_we) page <= ld_val[PGW-1:0];
    end
  end

  assign mem_addr = dir_sel ? {page, dir_off} : cur;
  assign rd_data  = regs[rd_idx];
  assign ptr_out  = ptr;
  assign page_out = page;
endmodule

module aux_addr_unit_chk #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int PGW  = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_en,
  input logic                    dir_sel,
  input logic [2:0]              mode,
  input logic                    ptr_ld,
  input logic [$clog2(NREG)-1:0] ptr_new,
  input logic                    ptr_we,
  input logic                    ar_we,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic [DW-1:0]           ld_val,
  input logic [$clog2(NREG)-1:0] ptr,
  input logic [DW-1:0]           mem_addr,
  input logic [DW-1:0]           regs [NREG]
);
  assert_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !dir_sel && mode == 3'd1 && !(ar_we && wr_idx == ptr)
    |=> regs[$past(ptr)] == $past(mem_addr) + DW'(1));

  assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !dir_sel && mode == 3'd2 && !(ar_we && wr_idx == ptr)
    |=> regs[$past(ptr)] == $past(mem_addr) - DW'(1));

  assert_ptr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !dir_sel && ptr_ld && !ptr_we |=> ptr == $past(ptr_new));

  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we && !(acc_en && !dir_sel && ptr_ld) |=> $stable(ptr));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ar_we |=> regs[$past(wr_idx)] == $past(ld_val));

  assert_direct_nomod_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dir_sel && !ar_we && !ptr_we |=> regs[ptr] == $past(regs[ptr]));
endmodule

bind aux_addr_unit aux_addr_unit_chk #(.DW(DW), .NREG(NREG), .PGW(PGW)) u_chk (.*);

// File: tb/aux_addr_unit_test.sv
module aux_addr_unit_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] bus_data = 0, imm_data = 0;
  logic src_imm = 0, ar_we = 0, ptr_we = 0, page_we = 0, acc_en = 0, ptr_ld = 0, dir_sel = 0;
  logic [2:0] wr_idx = 0, mode = 0, ptr_new = 0, rd_idx = 0;
  logic [6:0] dir_off = 0;
  logic [15:0] mem_addr, rd_data;
  logic [2:0] ptr_out;
  logic [8:0] page_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aux_addr_unit uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear();
    ar_we = 0; ptr_we = 0; page_we = 0; acc_en = 0; ptr_ld = 0; dir_sel = 0; mode = 0;
  endtask

  task automatic load_reg(input logic [2:0] i, input logic [15:0] v, input bit imm);
    @(negedge clk); clear(); ar_we = 1; wr_idx = i; src_imm = imm;
    if (imm) begin imm_data = v; bus_data = ~v; end else begin bus_data = v; imm_data = ~v; end
    @(negedge clk); clear();
  endtask

  task automatic load_ptr(input logic [2:0] p);
    @(negedge clk); clear(); ptr_we = 1; src_imm = 1; imm_data = {13'h1fff, p};
    @(negedge clk); clear();
  endtask

  task automatic access(input logic [2:0] m, input string req, input logic [15:0] exp_addr);
    @(negedge clk); clear(); acc_en = 1; mode = m; #1;
    check(req, mem_addr, exp_addr);
    @(negedge clk); clear();
  endtask

  task automatic read_reg(input logic [2:0] i, input string req, input logic [15:0] exp);
    rd_idx = i; #1; check(req, rd_data, exp);
  endtask

  task automatic t_reset();
    check("R1 ptr", ptr_out, 0);
    check("R1 page", page_out, 0);
    for (int i = 0; i < 8; i++) read_reg(3'(i), "R1 reg", 16'h0);
  endtask

  task automatic t_loads();
    load_reg(3, 16'h1234, 1);
    read_reg(3, "R2 imm load", 16'h1234);
    load_reg(4, 16'hbeef, 0);
    read_reg(4, "R2 bus load", 16'hbeef);
    load_ptr(3);
    check("R3 ptr load", ptr_out, 3);
    @(negedge clk); page_we = 1; src_imm = 0; bus_data = 16'hfe05;
    @(negedge clk); clear();
    check("R3 page load", page_out, 9'h005);
  endtask

  task automatic t_incdec();
    access(1, "R4 addr before inc", 16'h1234);
    read_reg(3, "R5 inc", 16'h1235);
    access(2, "R4 addr before dec", 16'h1235);
    access(2, "R5 dec", 16'h1234);
    read_reg(3, "R5 dec", 16'h1233);
    load_reg(3, 16'hffff, 1);
    access(1, "R5 wrap addr", 16'hffff);
    read_reg(3, "R5 wrap up", 16'h0000);
    access(2, "R5 wrap addr", 16'h0000);
    read_reg(3, "R5 wrap down", 16'hffff);
  endtask

  task automatic t_index();
    load_reg(0, 16'h0010, 1);
    load_reg(3, 16'h0100, 0);
    access(3, "R6 add addr", 16'h0100);
    read_reg(3, "R6 add", 16'h0110);
    access(4, "R6 sub addr", 16'h0110);
    access(4, "R6 sub addr", 16'h0100);
    read_reg(3, "R6 sub", 16'h00f0);
  endtask

  task automatic t_nomod();
    access(0, "R8 code0 addr", 16'h00f0);
    access(7, "R8 code7 addr", 16'h00f0);
    read_reg(3, "R8 unchanged", 16'h00f0);
    @(negedge clk); mode = 1; acc_en = 0; @(negedge clk); clear();
    read_reg(3, "R8 no strobe", 16'h00f0);
  endtask

  task automatic t_reverse();
    logic [15:0] fwd [10] = '{16'h0, 16'h8, 16'h4, 16'hc, 16'h2, 16'ha, 16'h6, 16'he, 16'h1, 16'h9};
    logic [15:0] bwd [3] = '{16'h0, 16'hf, 16'h7};
    load_reg(0, 16'h0008, 1);
    load_reg(1, 16'h0000, 1);
    load_ptr(1);
    for (int k = 0; k < 10; k++) access(5, "R7 rev add", fwd[k]);
    load_reg(1, 16'h0000, 0);
    for (int k = 0; k < 3; k++) access(6, "R7 rev sub", bwd[k]);
  endtask

  task automatic t_ptr_switch();
    load_reg(5, 16'h0500, 1);
    load_reg(2, 16'h0200, 1);
    load_ptr(2);
    @(negedge clk); acc_en = 1; mode = 1; ptr_ld = 1; ptr_new = 5; #1;
    check("R9 addr from old ptr", mem_addr, 16'h0200);
    @(negedge clk); clear(); #1;
    check("R9 new ptr", ptr_out, 5);
    read_reg(2, "R9 old reg modified", 16'h0201);
    read_reg(5, "R9 new reg untouched", 16'h0500);
    access(0, "R9 next addr", 16'h0500);
    check("R9 ptr holds", ptr_out, 5);
  endtask

  task automatic t_direct();
    @(negedge clk); page_we = 1; src_imm = 1; imm_data = 16'h01ff;
    @(negedge clk); clear(); dir_sel = 1; dir_off = 7'h7f; #1;
    check("R10 top addr", mem_addr, 16'hffff);
    @(negedge clk); page_we = 1; src_imm = 1; imm_data = 16'h0001; dir_sel = 1; dir_off = 7'h05;
    @(negedge clk); clear(); dir_sel = 1; acc_en = 1; mode = 1; ptr_ld = 1; ptr_new = 0; #1;
    check("R10 page1 addr", mem_addr, 16'h0085);
    @(negedge clk); clear();
    read_reg(5, "R10 no modify", 16'h0500);
    check("R10 ptr kept", ptr_out, 5);
  endtask

  task automatic t_priority();
    @(negedge clk); acc_en = 1; mode = 1; ar_we = 1; wr_idx = 5; src_imm = 1; imm_data = 16'haaaa;
    ptr_we = 1; ptr_ld = 1; ptr_new = 6;
    @(negedge clk); clear();
    read_reg(5, "R11 write beats modify", 16'haaaa);
    check("R11 ptr write beats load", ptr_out, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_loads();
    t_incdec();
    t_index();
    t_nomod();
    t_reverse();
    t_ptr_switch();
    t_direct();
    t_priority();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule